// File: doc/BRIEF.md
# Receive Frame Length Guard

This block tracks how many bytes of an incoming frame have arrived and compares that count against a software-programmed ceiling. The ceiling counts CRC bytes as part of the frame. A receive datapath pulses `frame_start` when a new frame begins and pulses `byte_rx` once for each byte it delivers. The block then keeps a 13-bit running count and raises `over_len` when a byte arrives after the count has already reached the ceiling.

A CPU reaches the block through a byte-wide port with two addresses. Address 0 holds bits 7:0 and address 1 holds bits 12:8. Writes always go to the ceiling register. Software writes the low byte first, and the high-byte write commits both halves together. Reads return either the ceiling or the live count, chosen by the `test_sel` input. Reading the low byte of the count freezes its upper bits, so the high-byte read that follows is coherent.

The ceiling values 0 to 3 are reserved. The block treats any value below 4 as 4 when it compares, while readback still returns the value that was written.

Top module: `rxlen_guard`

## Requirements
- R1: After reset the ceiling register holds 0x800, the byte count is 0 and `over_len` is 0.
- R2: A write to address 0 only stages the byte and leaves the ceiling unchanged. A write to address 1 loads the ceiling with bits 12:8 from that write and bits 7:0 from the staged byte, effective the next cycle.
- R3: Bits 7:5 of a write to address 1 are discarded. Reads at address 1 always return 0 in bits 7:5.
- R4: With `test_sel` = 1, address 0 reads ceiling bits 7:0 and address 1 reads ceiling bits 12:8 in bits 4:0. With `test_sel` = 0, both addresses read the byte count instead.
- R5: `frame_start` clears the count and `over_len` in the next cycle. It takes priority over a `byte_rx` in the same cycle, and that byte is not counted.
- R6: Each `byte_rx` cycle without `frame_start` adds one to the count while the count is below the effective ceiling.
- R7: A `byte_rx` that arrives when the count already equals the effective ceiling sets `over_len` and leaves the count unchanged. `over_len` stays set until the next `frame_start`.
- R8: The effective ceiling is the programmed value, or 4 when the programmed value is below 4. Readback returns the programmed value.
- R9: A read of address 0 with `test_sel` = 0 captures count bits 12:8. Later reads of address 1 with `test_sel` = 0 return that captured value, not the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe (drives the count snapshot) |
| cpu_addr | input | 1 | 0 selects bits 7:0, 1 selects bits 12:8 |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, combinational from address and `test_sel` |
| test_sel | input | 1 | 1 reads the ceiling, 0 reads the count |
| frame_start | input | 1 | One-cycle pulse at the start of an incoming frame |
| byte_rx | input | 1 | One pulse per received byte |
| over_len | output | 1 | Sticky flag: the frame exceeded the ceiling |

## Verification
The count properties assume the ceiling is not lowered in the middle of a frame. A ceiling that drops below the current count would leave the count above the new limit. The bench reprograms the ceiling only before it pulses `frame_start`. The write properties assume software writes the low byte before the high byte, and every write in the bench follows that order. The strobes are single-cycle, synchronous levels that the bench changes only on falling clock edges, so each property sees one clean sample per cycle.

// File: rtl/rxlen_pkg.sv
`timescale 1ns/1ps
package rxlen_pkg;
   // which half of the split register a CPU access selects
   typedef enum logic {
      HALF_LO = 1'b0,
      HALF_HI = 1'b1
   } half_e;

   // what a read returns
   typedef enum logic {
      VIEW_COUNT = 1'b0,
      VIEW_LIMIT = 1'b1
   } view_e;

   localparam int unsigned DEF_CNT_W     = 13;
   localparam int unsigned DEF_BUS_W     = 8;
   localparam int unsigned DEF_MIN_LIMIT = 4;
   localparam int unsigned DEF_RST_LIMIT = 32'h800;
endpackage

// File: rtl/rxlen_limit_reg.sv
`timescale 1ns/1ps
module rxlen_limit_reg #(
   parameter int unsigned CNT_W     = 13,
   parameter int unsigned BUS_W     = 8,
   parameter int unsigned RST_LIMIT = 32'h800
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic [BUS_W-1:0] wdata,
   output logic [CNT_W-1:0] limit_q
);
   localparam int unsigned HI_W = CNT_W - BUS_W;
   localparam logic [CNT_W-1:0] RST_VAL = CNT_W'(RST_LIMIT);

   logic [BUS_W-1:0] stage_q;

   // low half waits here until the high half arrives
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= RST_VAL[BUS_W-1:0];
      end else if (wr_lo) begin
         stage_q <= wdata;
      end
   end

   // high-half write commits both halves at once; reserved bits fall away
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         limit_q <= RST_VAL;
      end else if (wr_hi) begin
         limit_q <= {wdata[HI_W-1:0], stage_q};
      end
   end
endmodule

// File: rtl/rxlen_byte_counter.sv
`timescale 1ns/1ps
module rxlen_byte_counter #(
   parameter int unsigned CNT_W     = 13,
   parameter int unsigned MIN_LIMIT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start,
   input  logic             byte_rx,
   input  logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] count_q,
   output logic             over_q
);
   localparam logic [CNT_W-1:0] MIN_VAL = CNT_W'(MIN_LIMIT);

   logic [CNT_W-1:0] eff_limit;
   logic             at_cap;

   // reserved small ceilings behave as the smallest legal one
   always_comb begin
      eff_limit = (limit < MIN_VAL) ? MIN_VAL : limit;
      at_cap    = (count_q >= eff_limit);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
         over_q  <= 1'b0;
      end else if (frame_start) begin
         count_q <= '0;
         over_q  <= 1'b0;
      end else if (byte_rx) begin
         if (at_cap) begin
            over_q <= 1'b1;
         end else begin
            count_q <= count_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/rxlen_read_port.sv
`timescale 1ns/1ps
module rxlen_read_port
   import rxlen_pkg::*;
#(
   parameter int unsigned CNT_W       = 13,
   parameter int unsigned BUS_W       = 8,
   parameter bit          SNAPSHOT_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd,
   input  half_e            half,
   input  view_e            view,
   input  logic [CNT_W-1:0] limit,
   input  logic [CNT_W-1:0] count,
   output logic [BUS_W-1:0] rdata
);
   localparam int unsigned HI_W  = CNT_W - BUS_W;
   localparam int unsigned PAD_W = BUS_W - HI_W;

   logic [HI_W-1:0] cnt_hi;

   generate
      if (SNAPSHOT_EN) begin : g_snap
         logic [HI_W-1:0] snap_q;
         // a low-byte count read freezes the upper bits for the follow-up read
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               snap_q <= '0;
            end else if (rd && half == HALF_LO && view == VIEW_COUNT) begin
               snap_q <= count[CNT_W-1:BUS_W];
            end
         end
         assign cnt_hi = snap_q;
      end else begin : g_live
         assign cnt_hi = count[CNT_W-1:BUS_W];
      end
   endgenerate

   always_comb begin
      unique case ({view, half})
         {VIEW_LIMIT, HALF_LO}: rdata = limit[BUS_W-1:0];
         {VIEW_LIMIT, HALF_HI}: rdata = {{PAD_W{1'b0}}, limit[CNT_W-1:BUS_W]};
         {VIEW_COUNT, HALF_LO}: rdata = count[BUS_W-1:0];
         default:               rdata = {{PAD_W{1'b0}}, cnt_hi};
      endcase
   end
endmodule

// File: rtl/rxlen_guard.sv
`timescale 1ns/1ps
module rxlen_guard
   import rxlen_pkg::*;
#(
   parameter int unsigned CNT_W       = DEF_CNT_W,
   parameter int unsigned BUS_W       = DEF_BUS_W,
   parameter int unsigned MIN_LIMIT   = DEF_MIN_LIMIT,
   parameter int unsigned RST_LIMIT   = DEF_RST_LIMIT,
   parameter bit          SNAPSHOT_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_wr,
   input  logic             cpu_rd,
   input  logic             cpu_addr,
   input  logic [BUS_W-1:0] cpu_wdata,
   output logic [BUS_W-1:0] cpu_rdata,
   input  logic             test_sel,
   input  logic             frame_start,
   input  logic             byte_rx,
   output logic             over_len
);
   // elaboration-time parameter checks
   generate
      if (CNT_W <= BUS_W || CNT_W >= 2 * BUS_W) begin : g_bad_width
         $error("rxlen_guard: CNT_W must lie strictly between BUS_W and 2*BUS_W");
      end
      if (MIN_LIMIT < 1 || MIN_LIMIT >= (1 << CNT_W)) begin : g_bad_min
         $error("rxlen_guard: MIN_LIMIT out of range");
      end
      if (RST_LIMIT < MIN_LIMIT || RST_LIMIT >= (1 << CNT_W)) begin : g_bad_rst
         $error("rxlen_guard: RST_LIMIT must be legal and fit CNT_W");
      end
   endgenerate

   half_e            half;
   view_e            view;
   logic             wr_lo;
   logic             wr_hi;
   logic [CNT_W-1:0] limit_q;
   logic [CNT_W-1:0] count_q;

   always_comb begin
      half  = half_e'(cpu_addr);
      view  = view_e'(test_sel);
      wr_lo = cpu_wr && (half == HALF_LO);
      wr_hi = cpu_wr && (half == HALF_HI);
   end

   rxlen_limit_reg #(
      .CNT_W     (CNT_W),
      .BUS_W     (BUS_W),
      .RST_LIMIT (RST_LIMIT)
   ) u_limit (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_lo   (wr_lo),
      .wr_hi   (wr_hi),
      .wdata   (cpu_wdata),
      .limit_q (limit_q)
   );

   rxlen_byte_counter #(
      .CNT_W     (CNT_W),
      .MIN_LIMIT (MIN_LIMIT)
   ) u_count (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .byte_rx     (byte_rx),
      .limit       (limit_q),
      .count_q     (count_q),
      .over_q      (over_len)
   );

   rxlen_read_port #(
      .CNT_W       (CNT_W),
      .BUS_W       (BUS_W),
      .SNAPSHOT_EN (SNAPSHOT_EN)
   ) u_read (
      .clk   (clk),
      .rst_n (rst_n),
      .rd    (cpu_rd),
      .half  (half),
      .view  (view),
      .limit (limit_q),
      .count (count_q),
      .rdata (cpu_rdata)
   );
endmodule

// File: rtl/rxlen_guard_chk.sv
`timescale 1ns/1ps
module rxlen_guard_chk #(
   parameter int unsigned CNT_W = 13,
   parameter int unsigned BUS_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cpu_wr,
   input logic             cpu_addr,
   input logic [BUS_W-1:0] cpu_wdata,
   input logic             frame_start,
   input logic             byte_rx,
   input logic [CNT_W-1:0] limit_q,
   input logic [CNT_W-1:0] count_q,
   input logic             over_len
);
   localparam int unsigned HI_W = CNT_W - BUS_W;

   // R1
   rst_state_chk: assert property (@(posedge clk) $rose(rst_n) |-> (count_q == '0) && !over_len);

   // R2
   lim_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_wr && cpu_addr) |=> $stable(limit_q));

   // R3
   lim_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_wr && cpu_addr |=> limit_q[CNT_W-1:BUS_W] == $past(cpu_wdata[HI_W-1:0]));

   // R5
   cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (count_q == '0) && !over_len);

   // R6
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_rx && !frame_start |=> (count_q == $past(count_q) + 1'b1) || over_len);

   // R6
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_rx && !frame_start |=> $stable(count_q));

   // R7
   over_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      over_len && !frame_start |=> over_len);

   // R7
   over_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(over_len) |-> $past(byte_rx) && $stable(count_q));
endmodule

bind rxlen_guard rxlen_guard_chk #(
   .CNT_W (CNT_W),
   .BUS_W (BUS_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cpu_wr      (cpu_wr),
   .cpu_addr    (cpu_addr),
   .cpu_wdata   (cpu_wdata),
   .frame_start (frame_start),
   .byte_rx     (byte_rx),
   .limit_q     (limit_q),
   .count_q     (count_q),
   .over_len    (over_len)
);

// File: tb/rxlen_guard_test.sv
`timescale 1ns/1ps
module rxlen_guard_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_wr = 1'b0;
   logic       cpu_rd = 1'b0;
   logic       cpu_addr = 1'b0;
   logic [7:0] cpu_wdata = 8'h00;
   logic [7:0] cpu_rdata;
   logic       test_sel = 1'b0;
   logic       frame_start = 1'b0;
   logic       byte_rx = 1'b0;
   logic       over_len;

   int vectors = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   rxlen_guard uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .cpu_wr      (cpu_wr),
      .cpu_rd      (cpu_rd),
      .cpu_addr    (cpu_addr),
      .cpu_wdata   (cpu_wdata),
      .cpu_rdata   (cpu_rdata),
      .test_sel    (test_sel),
      .frame_start (frame_start),
      .byte_rx     (byte_rx),
      .over_len    (over_len)
   );

   task automatic check(input string req, input int got, input int exp);
      vectors++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   task automatic rd(input logic sel, input logic a, output logic [7:0] d);
      @(negedge clk);
      test_sel = sel; cpu_rd = 1'b1; cpu_addr = a;
      #1 d = cpu_rdata;
      @(negedge clk);
      cpu_rd = 1'b0;
   endtask

   task automatic set_limit(input int v);
      wr(1'b0, v[7:0]);
      wr(1'b1, {3'b000, v[12:8]});
   endtask

   task automatic start_frame();
      @(negedge clk);
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
   endtask

   task automatic send_bytes(input int n);
      @(negedge clk);
      for (int i = 0; i < n; i++) begin
         byte_rx = 1'b1;
         @(negedge clk);
      end
      byte_rx = 1'b0;
   endtask

   task automatic read_count(output int v);
      logic [7:0] lo, hi;
      rd(1'b0, 1'b0, lo);
      rd(1'b0, 1'b1, hi);
      v = {hi[4:0], lo};
   endtask

   task automatic t_reset();
      logic [7:0] d;
      int c;
      rd(1'b1, 1'b0, d); check("R1 limit lo", d, 8'h00);
      rd(1'b1, 1'b1, d); check("R1 limit hi", d, 8'h08);
      read_count(c);     check("R1 count", c, 0);
      check("R1 over_len", over_len, 0);
   endtask

   task automatic t_write_order();
      logic [7:0] d;
      set_limit(13'h123);
      rd(1'b1, 1'b0, d); check("R4 limit lo", d, 8'h23);
      rd(1'b1, 1'b1, d); check("R4 limit hi", d, 8'h01);
      wr(1'b0, 8'h55);
      rd(1'b1, 1'b0, d); check("R2 staged lo not applied", d, 8'h23);
      wr(1'b1, 8'h00);
      rd(1'b1, 1'b0, d); check("R2 commit lo", d, 8'h55);
      rd(1'b1, 1'b1, d); check("R2 commit hi", d, 8'h00);
   endtask

   task automatic t_reserved();
      logic [7:0] d;
      wr(1'b0, 8'h34);
      wr(1'b1, 8'hE5);
      rd(1'b1, 1'b1, d); check("R3 reserved bits dropped", d, 8'h05);
      rd(1'b1, 1'b0, d); check("R3 low byte", d, 8'h34);
   endtask

   task automatic t_count();
      int c;
      set_limit(10);
      start_frame();
      send_bytes(7);
      read_count(c); check("R6 count 7", c, 7);
      check("R6 no flag", over_len, 0);
      start_frame();
      read_count(c); check("R5 cleared", c, 0);
   endtask

   task automatic t_over();
      int c;
      set_limit(10);
      start_frame();
      send_bytes(10);
      read_count(c); check("R6 count at limit", c, 10);
      check("R7 flag clear at limit", over_len, 0);
      send_bytes(1);
      check("R7 flag set", over_len, 1);
      read_count(c); check("R7 count held", c, 10);
      send_bytes(3);
      check("R7 flag sticky", over_len, 1);
      start_frame();
      check("R5 flag cleared", over_len, 0);
   endtask

   task automatic t_min();
      logic [7:0] d;
      int c;
      set_limit(2);
      rd(1'b1, 1'b0, d); check("R8 readback programmed", d, 8'h02);
      start_frame();
      send_bytes(4);
      check("R8 no flag at 4", over_len, 0);
      send_bytes(1);
      read_count(c); check("R8 count clamps at 4", c, 4);
      check("R8 flag beyond 4", over_len, 1);
   endtask

   task automatic t_snapshot();
      logic [7:0] d;
      set_limit(13'h400);
      start_frame();
      send_bytes(300);
      rd(1'b0, 1'b0, d); check("R9 lo byte 300", d, 8'h2C);
      send_bytes(256);
      rd(1'b0, 1'b1, d); check("R9 hi from snapshot", d, 8'h01);
      rd(1'b0, 1'b0, d); check("R9 lo byte 556", d, 8'h2C);
      rd(1'b0, 1'b1, d); check("R9 hi after new snapshot", d, 8'h02);
   endtask

   task automatic t_collide();
      int c;
      set_limit(20);
      start_frame();
      send_bytes(5);
      @(negedge clk);
      frame_start = 1'b1; byte_rx = 1'b1;
      @(negedge clk);
      frame_start = 1'b0; byte_rx = 1'b0;
      read_count(c); check("R5 start beats byte", c, 0);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         errors++;
         vectors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_write_order();
      t_reserved();
      t_count();
      t_over();
      t_min();
      t_snapshot();
      t_collide();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule